// File: doc/BRIEF.md
# Quadratic Permutation Address Generator

This block produces the read or write addresses of a quadratic permutation interleaver as a stream, with one set of addresses per clock cycle. A block is opened with a start pulse that carries the block length K and the two coefficients. The block then emits the permuted position (a·i + b·i²) mod K for every index i of the block. It uses no multiplier and no divider. Each address follows from the previous one through a second-order difference: one modular add for the address and one for the difference. Each modular add is a plain add followed by a conditional subtraction of K.

In sequential mode lane 0 carries the whole sequence, one index per cycle. In parallel mode the block is cut into `LANES` equal segments of length K/`LANES`, and lane j walks the segment that begins at index j·K/`LANES`. The starting address and difference of each lane are found during a short setup walk before the first valid cycle. A quadratic permutation with valid coefficients maps the lanes to distinct memory banks on every cycle, so a banked memory can be fed with no conflicts. Callers keep the coefficients below K, and in parallel mode pick a K that `LANES` divides.

Top module: `qpp_addr_gen`

## Requirements
- R1: In sequential mode the t-th valid cycle after a start (t = 0 .. K-1) shows (a·t + b·t²) mod K on lane 0. Bits [12:0] of `addr_bus` hold lane 0. Valid stays high with no gap for exactly K cycles.
- R2: `addr_last` is high together with `addr_vld` on the final valid cycle of a block only. `busy` is low in the cycle that follows that final cycle.
- R3: In parallel mode (`par_en` = 1 at start) lane j, on bits [13·j+12 : 13·j], shows (a·n + b·n²) mod K with n = j·K/`LANES` + t on the t-th valid cycle. The block lasts exactly K/`LANES` valid cycles.
- R4: In sequential mode the lanes 1 .. `LANES`-1 read zero on every cycle.
- R5: A start pulse that arrives while `busy` is high is ignored, and so are the length, coefficient and mode values that come with it. The running block's stream is unchanged.
- R6: Once reset is released, `busy`, `addr_vld` and `addr_last` are low and `addr_bus` is zero.
- R7: Count the edge that samples the start pulse as edge 1. `addr_vld` is first high after edge 2 in sequential mode, and after edge 2 + (`LANES`-1)·K/`LANES` in parallel mode.
- R8: `busy` is high from the edge that accepts a start until the final valid cycle. Every address output while valid is below K.
- R9: The addresses of one block, over all its cycles and all active lanes, are pairwise distinct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Opens a block; taken only while idle |
| par_en | input | 1 | 1 selects the multi-lane mode for the block |
| blk_len | input | 13 | Block length K, sampled at start |
| coef_a | input | 13 | Linear coefficient, below K |
| coef_b | input | 13 | Quadratic coefficient, below K |
| busy | output | 1 | A block is in setup or output |
| addr_vld | output | 1 | The lanes hold addresses this cycle |
| addr_last | output | 1 | Final address cycle of the block |
| addr_bus | output | 13·LANES | Lane addresses, lane j on bits [13·j+12 : 13·j] |

## Verification
The assertions watch, on every cycle, that each running lane stays below K and that valid runs without a gap until last. They also watch that busy drops right after last, that the latched block settings stay fixed while busy, and that busy only rises after a start. Whether the values are the right permutation values, whether the lanes start on the right segment offsets, and whether the setup latency and the distinctness across a whole block hold, only the bench's scenarios can show. It compares every lane on every valid cycle with an integer evaluation of the polynomial.

// File: rtl/qpp_pkg.sv
`timescale 1ns/1ps
// Shared width, state encoding and modular adder for the address generator.
// Assumes both operands of mod_add are already below the modulus.
package qpp_pkg;
    localparam int ADDR_W = 13;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_SETUP = 2'd1, ST_RUN = 2'd2} qpp_state_t;

    // (a + b) mod k via one add and one conditional subtract
    function automatic addr_t mod_add(input addr_t a, input addr_t b, input addr_t k);
        logic [ADDR_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= {1'b0, k}) s = s - {1'b0, k};
        return s[ADDR_W-1:0];
    endfunction
endpackage

// File: rtl/qpp_lane.sv
`timescale 1ns/1ps
// One difference engine: holds an address and its first difference, and
// advances both by modular adds (the second difference is the constant step).
// Assumes loaded values and step are below kmod.
module qpp_lane
    import qpp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ld,
    input  logic  adv,
    input  addr_t ld_pos,
    input  addr_t ld_diff,
    input  addr_t step,
    input  addr_t kmod,
    output addr_t pos,
    output addr_t diff
);
    // load a new starting point or step the recurrence one index forward
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos  <= '0;
            diff <= '0;
        end else if (ld) begin
            pos  <= ld_pos;
            diff <= ld_diff;
        end else if (adv) begin
            pos  <= mod_add(pos, diff, kmod);
            diff <= mod_add(diff, step, kmod);
        end
    end

    a_r8_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        adv && !ld |=> (pos < kmod) && (diff < kmod));
endmodule

// File: rtl/qpp_ctrl.sv
`timescale 1ns/1ps
// Sequencer: accepts a start while idle, runs the setup walk that hands each
// lane its segment start, then counts the output cycles of the block.
// Assumes LANES is a power of two, at least 2, and divides K in parallel mode.
module qpp_ctrl
    import qpp_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             par_en,
    input  addr_t            blk_len,
    output logic             accept,
    output logic             walk_adv,
    output logic [LANES-1:0] lane_ld,
    output logic [LANES-1:0] lane_on,
    output logic             lane_adv,
    output logic             busy,
    output logic             vld,
    output logic             last
);
    localparam int LSEL = $clog2(LANES);
    typedef logic [LSEL-1:0] lsel_t;

    qpp_state_t st;
    addr_t      widx, nxt, span, cnt;
    lsel_t      ptr, last_lane;
    logic       par_q;
    logic       hit, setup_done;

    assign hit        = (st == ST_SETUP) && (widx == nxt);
    assign setup_done = hit && (ptr == last_lane);
    assign accept     = (st == ST_IDLE) && start;
    assign walk_adv   = (st == ST_SETUP) && !setup_done;
    assign lane_adv   = (st == ST_RUN);
    assign busy       = (st != ST_IDLE);
    assign vld        = (st == ST_RUN);
    assign last       = (st == ST_RUN) && (cnt == span - addr_t'(1));

    // per-lane load strobe and activity mask
    for (genvar j = 0; j < LANES; j++) begin : g_sel
        assign lane_ld[j] = hit && (ptr == lsel_t'(j));
        assign lane_on[j] = (j == 0) || par_q;
    end

    // state machine with setup walk index and output cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            widx      <= '0;
            nxt       <= '0;
            span      <= '0;
            cnt       <= '0;
            ptr       <= '0;
            last_lane <= '0;
            par_q     <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st        <= ST_SETUP;
                    widx      <= '0;
                    nxt       <= '0;
                    ptr       <= '0;
                    par_q     <= par_en;
                    span      <= par_en ? (blk_len >> LSEL) : blk_len;
                    last_lane <= par_en ? lsel_t'(LANES - 1) : '0;
                end
                ST_SETUP: begin
                    if (hit) begin
                        ptr <= ptr + lsel_t'(1);
                        nxt <= nxt + span;
                    end
                    if (setup_done) begin
                        st  <= ST_RUN;
                        cnt <= '0;
                    end else begin
                        widx <= widx + addr_t'(1);
                    end
                end
                ST_RUN: begin
                    cnt <= cnt + addr_t'(1);
                    if (cnt == span - addr_t'(1)) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    a_r1_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        vld && !last |=> vld);
    a_r2_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !busy);
    a_r5_config_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(span) && $stable(par_q));
    a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

// File: rtl/qpp_addr_gen.sv
`timescale 1ns/1ps
// Quadratic permutation address generator. A walker engine steps from index 0
// during setup and hands its state to each lane at the lane's segment start;
// the lanes then step together, one index per cycle.
// Assumes coef_a, coef_b < blk_len and blk_len >= 2.
module qpp_addr_gen
    import qpp_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    par_en,
    input  logic [ADDR_W-1:0]       blk_len,
    input  logic [ADDR_W-1:0]       coef_a,
    input  logic [ADDR_W-1:0]       coef_b,
    output logic                    busy,
    output logic                    addr_vld,
    output logic                    addr_last,
    output logic [LANES*ADDR_W-1:0] addr_bus
);
    addr_t            kq, stepq, w_pos, w_diff;
    logic             accept, walk_adv, lane_adv;
    logic [LANES-1:0] lane_ld, lane_on;

    // latch modulus and second difference (2b mod K) for the block
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kq    <= '0;
            stepq <= '0;
        end else if (accept) begin
            kq    <= blk_len;
            stepq <= mod_add(coef_b, coef_b, blk_len);
        end
    end

    qpp_ctrl #(.LANES(LANES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .par_en(par_en),
        .blk_len(blk_len), .accept(accept), .walk_adv(walk_adv),
        .lane_ld(lane_ld), .lane_on(lane_on), .lane_adv(lane_adv),
        .busy(busy), .vld(addr_vld), .last(addr_last)
    );

    qpp_lane u_walk (
        .clk(clk), .rst_n(rst_n), .ld(accept), .adv(walk_adv),
        .ld_pos('0), .ld_diff(mod_add(coef_a, coef_b, blk_len)),
        .step(stepq), .kmod(kq), .pos(w_pos), .diff(w_diff)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        addr_t l_pos, l_diff;
        qpp_lane u_lane (
            .clk(clk), .rst_n(rst_n), .ld(lane_ld[j]), .adv(lane_adv),
            .ld_pos(w_pos), .ld_diff(w_diff), .step(stepq), .kmod(kq),
            .pos(l_pos), .diff(l_diff)
        );
        assign addr_bus[j*ADDR_W +: ADDR_W] = lane_on[j] ? l_pos : '0;

        a_r8_out_below_k: assert property (@(posedge clk) disable iff (!rst_n)
            addr_vld && lane_on[j] |-> l_pos < kq);
    end
endmodule

// File: tb/qpp_addr_gen_test.sv
`timescale 1ns/1ps
module qpp_addr_gen_test;
    localparam int LANES = 4;
    localparam int AW    = 13;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, par_en = 1'b0;
    logic [AW-1:0] blk_len = '0, coef_a = '0, coef_b = '0;
    logic busy, addr_vld, addr_last;
    logic [LANES*AW-1:0] addr_bus;
    int checks = 0, fails = 0;
    bit seen [8192];

    always #2 clk = ~clk;

    qpp_addr_gen #(.LANES(LANES)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .par_en(par_en),
        .blk_len(blk_len), .coef_a(coef_a), .coef_b(coef_b),
        .busy(busy), .addr_vld(addr_vld), .addr_last(addr_last), .addr_bus(addr_bus)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic longint qpp(longint k, longint a, longint b, longint n);
        return (a * n + b * n * n) % k;
    endfunction

    task automatic run_block(input int k, input int a, input int b, input bit par, input bit inject);
        int m, edges, lanes_on;
        m = par ? k / LANES : k;
        lanes_on = par ? LANES : 1;
        for (int i = 0; i < 8192; i++) seen[i] = 1'b0;
        @(negedge clk);
        start = 1'b1; par_en = par;
        blk_len = AW'(k); coef_a = AW'(a); coef_b = AW'(b);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R8 busy after start", busy, 1);
        edges = 1;
        while (!addr_vld && edges < 20000) begin
            @(posedge clk); edges++; @(negedge clk);
        end
        chk("R7 setup latency", edges, 2 + (lanes_on - 1) * m);
        for (int t = 0; t < m; t++) begin
            chk(par ? "R3 valid" : "R1 valid", addr_vld, 1);
            chk("R2 last flag", addr_last, t == m - 1);
            chk("R8 busy while running", busy, 1);
            for (int j = 0; j < LANES; j++) begin
                longint got, exp;
                got = addr_bus[j*AW +: AW];
                if (j < lanes_on) begin
                    exp = qpp(k, a, b, j * m + t);
                    chk(par ? "R3 lane address" : "R1 address", got, exp);
                    chk("R9 distinct", seen[got[12:0]], 0);
                    seen[got[12:0]] = 1'b1;
                end else begin
                    chk("R4 inactive lane zero", got, 0);
                end
            end
            if (inject && t == 3) begin
                start = 1'b1; par_en = ~par; blk_len = 13'd100; coef_a = 13'd1; coef_b = 13'd3;
            end else begin
                start = 1'b0; par_en = par;
                blk_len = AW'(k); coef_a = AW'(a); coef_b = AW'(b);
            end
            @(posedge clk); @(negedge clk);
        end
        start = 1'b0;
        chk("R2 valid low after last", addr_vld, 0);
        chk("R2 busy low after last", busy, 0);
        if (inject) chk("R5 busy start ignored", busy, 0);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R6 reset busy", busy, 0);
        chk("R6 reset valid", addr_vld, 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R6 idle busy", busy, 0);
        chk("R6 idle valid", addr_vld, 0);
        chk("R6 idle last", addr_last, 0);
        chk("R6 idle bus", addr_bus == '0, 1);
        run_block(40, 3, 10, 1'b0, 1'b0);     // R1 smallest length
        run_block(40, 3, 10, 1'b1, 1'b0);     // R3 smallest length, 4 lanes
        run_block(48, 7, 12, 1'b0, 1'b1);     // R5 start during run
        run_block(64, 7, 16, 1'b1, 1'b1);     // R3 with ignored start
        run_block(6144, 263, 480, 1'b0, 1'b0); // R1 largest length
        run_block(6144, 263, 480, 1'b1, 1'b0); // R3 largest length
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule